// File: doc/BRIEF.md
# I/O Expander Register Transaction Monitor

This block sits beside an I2C bus decoder and watches the stream of bus events it produces. It follows the traffic sent to a small four-register 8-bit I/O expander. It never drives the bus and never acknowledges anything. Each input event is a valid strobe with a 3-bit event code and one byte. The block follows the expander protocol. A START opens a transaction, the device address follows, then a register-pointer byte is written. After that come either data writes to that register, or a repeated START, an address-read and data reads from it. A STOP closes the transaction.

For every event that carries register traffic, the block raises a one-cycle report in the same cycle as the event. The report gives the register, the byte, the direction, and whether the byte is the pointer itself. An address outside the expander's two-address window raises a warning and abandons the transaction. Data written to the output-port register is mirrored onto eight lines, which gives a live copy of what the expander is driving.

Top module: `xpdr_txn_mon`

## Requirements
- R1: After reset, `dev_addr` is 0, `port_lines` is 8'hFF and neither `rpt_valid` nor `warn_addr` is asserted.
- R2: While idle, every event except START (code 0) is ignored. It produces no report, no warning and no change of `dev_addr` or `port_lines`.
- R3: After START, the first address event (code 3 address-read or code 4 address-write) is taken as the device address from `evt_byte[6:0]` (bit 7 ignored). If that address is 7'h20 or 7'h21, it appears on `dev_addr` from the next cycle. Other events in that state are ignored.
- R4: An address event whose 7-bit address is neither 7'h20 nor 7'h21 pulses `warn_addr` in the same cycle, produces no report, and returns the monitor to idle with `dev_addr` 0.
- R5: The first data-write (code 6) after a valid address latches `evt_byte` as the register pointer. It gives a report with `rpt_ptr`=1, `rpt_read`=0, and `rpt_reg`=`rpt_value`=the byte. Register values 0 (input port), 1 (output port), 2 (polarity inversion) and 3 (configuration) are valid. Any larger value is still latched but `rpt_bad_reg` is set.
- R6: Each further data-write in the write phase is reported with `rpt_ptr`=0, `rpt_read`=0, `rpt_value`=the byte and `rpt_reg`=the latched pointer. The pointer does not advance.
- R7: A repeated START (code 1) in the write phase gives no report and moves the monitor to wait for an address-read. Only an address-read is acted on there, and it is checked as in R3/R4. After that, each data-read (code 5) is reported with `rpt_read`=1 against the latched pointer.
- R8: A STOP (code 2) in the write data phase or the read data phase returns the monitor to idle and clears `dev_addr` to 0 from the next cycle.
- R9: A reported data-write to register 1 loads `port_lines` from the byte on the next clock edge, with bit i driving line i. No other event changes `port_lines`.
- R10: Code 7 and any cycle with `evt_valid` low are ignored in every state.
- R11: `rpt_valid` and `warn_addr` are single-cycle outputs present only in a cycle with `evt_valid` high. At most one of them is asserted per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_valid | input | 1 | Event strobe |
| evt_code | input | 3 | Event kind (0 START, 1 repeated START, 2 STOP, 3 addr-read, 4 addr-write, 5 data-read, 6 data-write, 7 reserved) |
| evt_byte | input | 8 | Byte carried by the event |
| rpt_valid | output | 1 | Report strobe, same cycle as the event |
| rpt_ptr | output | 1 | Report is a register-pointer write |
| rpt_read | output | 1 | Report direction, 1 = read |
| rpt_reg | output | 8 | Register the report refers to |
| rpt_value | output | 8 | Byte value of the report |
| rpt_bad_reg | output | 1 | Register number above 3 |
| warn_addr | output | 1 | Unexpected device address seen |
| dev_addr | output | 7 | Stored device address, 0 when no transaction is open |
| port_lines | output | 8 | Mirror of the last value written to register 1 |

## Verification
A wrong sequencer state shows at the ports on the very next event. A report appears where none should, or one is missing, or the address check is skipped or applied in the wrong state. A corrupted pointer shows up in `rpt_reg` on the next data report after the pointer write. A lost or stale device address is visible on `dev_addr` one cycle after the event that should have set or cleared it. A mirror fault shows on `port_lines` one cycle after a write to the output-port register.

// File: rtl/xpdr_pkg.sv
package xpdr_pkg;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_STOP    = 3'd2,
    EV_ADR_RD  = 3'd3,
    EV_ADR_WR  = 3'd4,
    EV_DAT_RD  = 3'd5,
    EV_DAT_WR  = 3'd6,
    EV_RSVD    = 3'd7
  } ev_code_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_PTR   = 3'd2,
    ST_WDATA = 3'd3,
    ST_RADDR = 3'd4,
    ST_RDATA = 3'd5
  } mon_state_e;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic adr_rd;
    logic adr_wr;
    logic dat_rd;
    logic dat_wr;
  } ev_flags_t;

endpackage

// File: rtl/xpdr_evt_dec.sv
module xpdr_evt_dec
  import xpdr_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] code,
  output ev_flags_t  flags
);

  always_comb begin
    flags = '0;
    if (valid) begin
      case (ev_code_e'(code))
        EV_START:  flags.start  = 1'b1;
        EV_RSTART: flags.rstart = 1'b1;
        EV_STOP:   flags.stop   = 1'b1;
        EV_ADR_RD: flags.adr_rd = 1'b1;
        EV_ADR_WR: flags.adr_wr = 1'b1;
        EV_DAT_RD: flags.dat_rd = 1'b1;
        EV_DAT_WR: flags.dat_wr = 1'b1;
        default:   flags = '0;
      endcase
    end
  end

endmodule

// File: rtl/xpdr_addr_chk.sv
module xpdr_addr_chk #(
  parameter int ADDR_W = 7,
  parameter int BASE   = 32,
  parameter int SPAN   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ok
);

  localparam int LIMIT = BASE + SPAN;

  logic [31:0] addr_ext;

  assign addr_ext = {{(32-ADDR_W){1'b0}}, addr};
  assign ok = (addr_ext >= 32'(BASE)) && (addr_ext < 32'(LIMIT));

endmodule

// File: rtl/xpdr_seq.sv
module xpdr_seq
  import xpdr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ev_flags_t         flags,
  input  logic [DATA_W-1:0] evt_byte,
  input  logic              addr_ok,
  output logic              rpt_valid,
  output logic              rpt_ptr,
  output logic              rpt_read,
  output logic [DATA_W-1:0] rpt_reg,
  output logic [DATA_W-1:0] rpt_value,
  output logic              rpt_bad_reg,
  output logic              warn,
  output logic [ADDR_W-1:0] dev_addr
);

  mon_state_e        state_q, state_d;
  logic [DATA_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] dev_q, dev_d;
  logic              is_adr;
  logic              ev_en;

  assign is_adr = flags.adr_rd | flags.adr_wr;
  assign ev_en  = |flags;

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    dev_d     = dev_q;
    rpt_valid = 1'b0;
    rpt_ptr   = 1'b0;
    rpt_read  = 1'b0;
    warn      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (flags.start) state_d = ST_ADDR;
      end
      ST_ADDR: begin
        if (is_adr) begin
          if (addr_ok) begin
            dev_d   = evt_byte[ADDR_W-1:0];
            state_d = ST_PTR;
          end else begin
            warn    = 1'b1;
            dev_d   = '0;
            state_d = ST_IDLE;
          end
        end
      end
      ST_PTR: begin
        if (flags.dat_wr) begin
          ptr_d     = evt_byte;
          rpt_valid = 1'b1;
          rpt_ptr   = 1'b1;
          state_d   = ST_WDATA;
        end
      end
      ST_WDATA: begin
        if (flags.rstart) begin
          state_d = ST_RADDR;
        end else if (flags.dat_wr) begin
          rpt_valid = 1'b1;
        end else if (flags.stop) begin
          dev_d   = '0;
          state_d = ST_IDLE;
        end
      end
      ST_RADDR: begin
        if (flags.adr_rd) begin
          if (addr_ok) begin
            dev_d   = evt_byte[ADDR_W-1:0];
            state_d = ST_RDATA;
          end else begin
            warn    = 1'b1;
            dev_d   = '0;
            state_d = ST_IDLE;
          end
        end
      end
      ST_RDATA: begin
        if (flags.dat_rd) begin
          rpt_valid = 1'b1;
          rpt_read  = 1'b1;
        end else if (flags.stop) begin
          dev_d   = '0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        dev_d   = '0;
        state_d = ST_IDLE;
      end
    endcase
  end

  assign rpt_reg     = rpt_ptr ? evt_byte : ptr_q;
  assign rpt_value   = evt_byte;
  assign rpt_bad_reg = rpt_valid && (rpt_reg >= DATA_W'(NUM_REGS));
  assign dev_addr    = dev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      dev_q   <= '0;
    end else if (ev_en) begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      dev_q   <= dev_d;
    end
  end

endmodule

// File: rtl/xpdr_mirror.sv
module xpdr_mirror #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lines
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lines[i] <= 1'b1;
      end else if (wr_en) begin
        lines[i] <= wr_data[i];
      end
    end
  end

endmodule

// File: rtl/xpdr_txn_mon.sv
module xpdr_txn_mon
  import xpdr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int DEV_BASE = 32,
  parameter int DEV_SPAN = 2,
  parameter int NUM_REGS = 4,
  parameter int PORT_REG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [2:0]        evt_code,
  input  logic [DATA_W-1:0] evt_byte,
  output logic              rpt_valid,
  output logic              rpt_ptr,
  output logic              rpt_read,
  output logic [DATA_W-1:0] rpt_reg,
  output logic [DATA_W-1:0] rpt_value,
  output logic              rpt_bad_reg,
  output logic              warn_addr,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] port_lines
);

  logic [1:0] rst_sync;
  logic       rst_int_n;
  ev_flags_t  flags;
  logic       addr_ok;
  logic       mirror_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  xpdr_evt_dec u_dec (
    .valid (evt_valid),
    .code  (evt_code),
    .flags (flags)
  );

  xpdr_addr_chk #(
    .ADDR_W (ADDR_W),
    .BASE   (DEV_BASE),
    .SPAN   (DEV_SPAN)
  ) u_achk (
    .addr (evt_byte[ADDR_W-1:0]),
    .ok   (addr_ok)
  );

  xpdr_seq #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .flags       (flags),
    .evt_byte    (evt_byte),
    .addr_ok     (addr_ok),
    .rpt_valid   (rpt_valid),
    .rpt_ptr     (rpt_ptr),
    .rpt_read    (rpt_read),
    .rpt_reg     (rpt_reg),
    .rpt_value   (rpt_value),
    .rpt_bad_reg (rpt_bad_reg),
    .warn        (warn_addr),
    .dev_addr    (dev_addr)
  );

  assign mirror_wr = rpt_valid && !rpt_ptr && !rpt_read &&
                     (rpt_reg == DATA_W'(PORT_REG));

  xpdr_mirror #(.W(DATA_W)) u_mirror (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (mirror_wr),
    .wr_data (rpt_value),
    .lines   (port_lines)
  );

endmodule

// File: rtl/xpdr_txn_mon_chk.sv
module xpdr_txn_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic [2:0] evt_code,
  input logic [7:0] evt_byte,
  input logic       rpt_valid,
  input logic       rpt_ptr,
  input logic       rpt_read,
  input logic [7:0] rpt_reg,
  input logic [7:0] rpt_value,
  input logic       warn_addr,
  input logic [6:0] dev_addr,
  input logic [7:0] port_lines
);

  // R11
  rpt_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid || warn_addr) |-> evt_valid);

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rpt_valid && warn_addr));

  // R4
  warn_clears_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_addr |=> (dev_addr == 7'd0));

  // R5
  ptr_report_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_ptr) |-> (evt_code == 3'd6 && rpt_reg == evt_byte && !rpt_read));

  // R9
  mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ptr && !rpt_read && rpt_reg == 8'd1)
      |=> (port_lines == $past(rpt_value)));

  // R9
  mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rpt_valid && !rpt_ptr && !rpt_read && rpt_reg == 8'd1) |=> $stable(port_lines));

  // R10
  rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == 3'd7) |-> (!rpt_valid && !warn_addr));

  // R10
  idle_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> $stable(dev_addr));

endmodule

bind xpdr_txn_mon xpdr_txn_mon_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .evt_valid  (evt_valid),
  .evt_code   (evt_code),
  .evt_byte   (evt_byte),
  .rpt_valid  (rpt_valid),
  .rpt_ptr    (rpt_ptr),
  .rpt_read   (rpt_read),
  .rpt_reg    (rpt_reg),
  .rpt_value  (rpt_value),
  .warn_addr  (warn_addr),
  .dev_addr   (dev_addr),
  .port_lines (port_lines)
);

// File: tb/xpdr_txn_mon_bench.sv
`timescale 1ns/1ps
module xpdr_txn_mon_bench;

  logic       clk;
  logic       rst_n;
  logic       evt_valid;
  logic [2:0] evt_code;
  logic [7:0] evt_byte;
  logic       rpt_valid, rpt_ptr, rpt_read, rpt_bad_reg, warn_addr;
  logic [7:0] rpt_reg, rpt_value, port_lines;
  logic [6:0] dev_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state: 0 idle, 1 addr, 2 ptr, 3 wdata, 4 raddr, 5 rdata
  int         m_state;
  logic [7:0] m_ptr;
  logic [6:0] m_dev;
  logic [7:0] m_mirror;

  xpdr_txn_mon u_xpdr_txn_mon (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_byte(evt_byte), .rpt_valid(rpt_valid), .rpt_ptr(rpt_ptr),
    .rpt_read(rpt_read), .rpt_reg(rpt_reg), .rpt_value(rpt_value),
    .rpt_bad_reg(rpt_bad_reg), .warn_addr(warn_addr), .dev_addr(dev_addr),
    .port_lines(port_lines)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit addr_good(input logic [7:0] b);
    return (b[6:0] == 7'h20) || (b[6:0] == 7'h21);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic [2:0] c, input logic [7:0] b);
    logic       e_rv, e_ptr, e_rd, e_warn;
    logic [7:0] e_reg;
    int         n_state;
    logic [7:0] n_ptr, n_mirror;
    logic [6:0] n_dev;
    string      tag;
    @(negedge clk);
    evt_valid = v; evt_code = c; evt_byte = b;
    #1;
    e_rv = 0; e_ptr = 0; e_rd = 0; e_warn = 0; e_reg = m_ptr;
    n_state = m_state; n_ptr = m_ptr; n_dev = m_dev; n_mirror = m_mirror;
    tag = (m_state == 0) ? "R2" : "R3";
    if (v && c != 3'd7) begin
      case (m_state)
        0: if (c == 3'd0) n_state = 1;
        1: if (c == 3'd3 || c == 3'd4) begin
             if (addr_good(b)) begin n_dev = b[6:0]; n_state = 2; end
             else begin e_warn = 1; n_dev = 0; n_state = 0; tag = "R4"; end
           end
        2: if (c == 3'd6) begin
             e_rv = 1; e_ptr = 1; e_reg = b; n_ptr = b; n_state = 3; tag = "R5";
           end
        3: if (c == 3'd1) begin n_state = 4; tag = "R7"; end
           else if (c == 3'd6) begin
             e_rv = 1; tag = "R6";
             if (m_ptr == 8'd1) n_mirror = b;
           end else if (c == 3'd2) begin n_state = 0; n_dev = 0; tag = "R8"; end
        4: if (c == 3'd3) begin
             tag = "R7";
             if (addr_good(b)) begin n_dev = b[6:0]; n_state = 5; end
             else begin e_warn = 1; n_dev = 0; n_state = 0; tag = "R4"; end
           end
        5: if (c == 3'd5) begin e_rv = 1; e_rd = 1; tag = "R7"; end
           else if (c == 3'd2) begin n_state = 0; n_dev = 0; tag = "R8"; end
        default: n_state = 0;
      endcase
    end else begin
      tag = "R10";
    end
    chk({tag, "/R11 rpt_valid"}, 32'(rpt_valid), 32'(e_rv));
    chk({tag, "/R4 warn_addr"}, 32'(warn_addr), 32'(e_warn));
    chk("R3 dev_addr", 32'(dev_addr), 32'(m_dev));
    chk("R9 port_lines", 32'(port_lines), 32'(m_mirror));
    if (e_rv && rpt_valid) begin
      chk({tag, " rpt_ptr"}, 32'(rpt_ptr), 32'(e_ptr));
      chk({tag, " rpt_read"}, 32'(rpt_read), 32'(e_rd));
      chk({tag, " rpt_reg"}, 32'(rpt_reg), 32'(e_reg));
      chk({tag, " rpt_value"}, 32'(rpt_value), 32'(b));
      chk("R5 rpt_bad_reg", 32'(rpt_bad_reg), 32'(e_reg > 8'd3));
    end
    m_state = n_state; m_ptr = n_ptr; m_dev = n_dev; m_mirror = n_mirror;
  endtask

  initial begin
    #300000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    evt_valid = 0; evt_code = 0; evt_byte = 0;
    m_state = 0; m_ptr = 0; m_dev = 0; m_mirror = 8'hFF;
    rst_n = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 dev_addr", 32'(dev_addr), 32'd0);
    chk("R1 port_lines", 32'(port_lines), 32'hFF);
    chk("R1 rpt_valid", 32'(rpt_valid), 32'd0);
    chk("R1 warn_addr", 32'(warn_addr), 32'd0);

    // R2 idle ignores non-START events
    send(1, 3'd6, 8'h01); send(1, 3'd4, 8'h20); send(1, 3'd2, 8'h00);
    // R5/R6/R9 write to output port, pointer stays
    send(1, 3'd0, 8'h00); send(1, 3'd4, 8'h20); send(1, 3'd6, 8'h01);
    send(1, 3'd6, 8'hA5); send(1, 3'd6, 8'h3C); send(0, 3'd6, 8'h00);
    send(1, 3'd7, 8'h55); send(1, 3'd2, 8'h00);
    // R7 repeated start read of configuration, R8 stop
    send(1, 3'd0, 8'h00); send(1, 3'd4, 8'h21); send(1, 3'd6, 8'h03);
    send(1, 3'd1, 8'h00); send(1, 3'd4, 8'h21); send(1, 3'd3, 8'hA1);
    send(1, 3'd5, 8'h77); send(1, 3'd5, 8'h78); send(1, 3'd2, 8'h00);
    // R4 bad address
    send(1, 3'd0, 8'h00); send(1, 3'd3, 8'h22); send(1, 3'd6, 8'h01);
    // R5 invalid pointer, R9 mirror untouched by other register
    send(1, 3'd0, 8'h00); send(1, 3'd4, 8'h20); send(1, 3'd6, 8'h09);
    send(1, 3'd6, 8'h00); send(1, 3'd2, 8'h00);
    // R4 bad address on read side
    send(1, 3'd0, 8'h00); send(1, 3'd4, 8'h20); send(1, 3'd6, 8'h01);
    send(1, 3'd1, 8'h00); send(1, 3'd3, 8'h1F); send(1, 3'd5, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] c;
      logic [7:0] b;
      int         r;
      r = int'($urandom % 16);
      if (r < 3) c = 3'd0;
      else if (r < 5) c = 3'd6;
      else c = 3'($urandom % 8);
      b = 8'($urandom);
      if (c == 3'd3 || c == 3'd4) begin
        r = int'($urandom % 8);
        if (r < 3) b = {b[7], 7'h20};
        else if (r < 6) b = {b[7], 7'h21};
      end else if (c == 3'd6 && m_state == 2) begin
        b = 8'($urandom % 6);
      end
      send(($urandom % 10) != 0, c, b);
    end

    @(negedge clk);
    evt_valid = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule